// File: doc/BRIEF.md
# DDR Read Capture-Phase Trainer

This block picks the receive capture phase for a double-data-rate serial read link. In the dummy window of a training read, the memory sends a fixed 8-bit learning byte on every data line in use. A front-end delay line, which is not part of this block, samples the line at several capture phases. For every phase and every lane it hands over two bits per clock: the bit sampled first and the bit sampled second. After four such beats the trainer has a full byte for each phase and lane. It compares that byte with the learning pattern and marks the phase as failing if any active lane differs.

A training run is started with a one-cycle `start` pulse and can span several reads. A phase survives only if it matched on every read of the run. When the run ends, the trainer selects the centre of the longest unbroken run of surviving phases, holds that phase for normal data capture, and pulses `done`. If no phase survives, the trainer raises `no_eye` and keeps the phase it held before.

The learning pattern sits in a small register. It resets to 00110100, a byte that holds slow and fast edges in both directions. Software can load a different pattern while the trainer is idle.

Top module: `ddr_eye_trainer`

## Requirements
- R1: After reset, `pattern_q` is 8'h34, `phase_sel` is NPHASE/2 (4 by default), and `busy`, `done`, `no_eye` and `pass_mask` are all 0.
- R2: A cycle with `pat_we` high while `busy` is low loads `pat_wdata` into `pattern_q`. A write while `busy` is high is ignored.
- R3: A read takes four accepted beats (`samp_valid` high). In beat k (0..3), the bit for phase p and lane l at index p*NLANE+l of `samp_first` is byte bit 7-2k, and the same index of `samp_second` is bit 6-2k. A phase passes a read only if its byte equals `pattern_q` on every active lane.
- R4: `lane_mode` is latched at start: 0 makes lane 0 active, 1 makes lanes 0 and 1 active, and 2 or 3 make all lanes active. Data on inactive lanes has no effect.
- R5: `reps` is latched at start, and a value of 0 counts as 1. The run ends after that many reads. Bit p of `pass_mask` is 1 only if phase p passed every read of the run.
- R6: At the end of a run with at least one passing phase, `phase_sel` becomes s+(n-1)/2 (integer division). Here s is the first phase and n the length of the longest run of consecutive passing phases. Phase indices do not wrap, and among runs of equal length the lowest one wins.
- R7: If no phase passes, `no_eye` goes to 1 with `done` and `phase_sel` keeps its earlier value. `no_eye` goes back to 0 when the next run is accepted.
- R8: A `start` while idle sets `busy` in the next cycle. `done` is a one-cycle pulse two cycles after the edge that accepts the final beat, and `busy` falls in the same cycle. A `start` while busy and beats while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_we | input | 1 | Pattern register write strobe |
| pat_wdata | input | 8 | New learning pattern |
| lane_mode | input | 2 | Active lane count select (0: one, 1: two, 2/3: all) |
| reps | input | REP_W | Reads per training run (0 counts as 1) |
| start | input | 1 | Begin a training run |
| samp_valid | input | 1 | A sample beat is present |
| samp_first | input | NPHASE*NLANE | Earlier bit of the beat, per phase and lane |
| samp_second | input | NPHASE*NLANE | Later bit of the beat, per phase and lane |
| busy | output | 1 | Training run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| no_eye | output | 1 | The last run found no passing phase |
| pass_mask | output | NPHASE | Phases that passed every read of the last run |
| phase_sel | output | PW | Selected capture phase |
| pattern_q | output | 8 | Current learning pattern |

## Verification
A corrupted pass mask shows up at the `done` pulse of the same run. It appears there either directly on `pass_mask` or as a `phase_sel` that points to a failing phase or misses the run centre. A wrong beat or read counter moves the `done` pulse off its fixed cycle, or stops it from arriving. Single-lane corruptions check the lane-mode masking, and run patterns with ties and edges check the selection rule. Every one of these faults is visible at the end of the run it affects.

// File: rtl/ddr_eye_trainer.sv
module ddr_eye_trainer #(
  parameter int NPHASE = 8,
  parameter int NLANE  = 4,
  parameter int REP_W  = 4,
  parameter logic [7:0] PAT_RST = 8'h34,
  localparam int PW = $clog2(NPHASE),
  localparam int NS = NPHASE * NLANE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_we,
  input  logic [7:0]       pat_wdata,
  input  logic [1:0]       lane_mode,
  input  logic [REP_W-1:0] reps,
  input  logic             start,
  input  logic             samp_valid,
  input  logic [NS-1:0]    samp_first,
  input  logic [NS-1:0]    samp_second,
  output logic             busy,
  output logic             done,
  output logic             no_eye,
  output logic [NPHASE-1:0] pass_mask,
  output logic [PW-1:0]    phase_sel,
  output logic [7:0]       pattern_q
);
  localparam logic [PW-1:0] RST_PHASE = PW'(NPHASE / 2);

  logic              run_q, fin_q;
  logic [1:0]        beat_q, mode_q;
  logic [REP_W-1:0]  rep_q, reps_q;
  logic [NS*8-1:0]   cap_q, cap_nx;
  logic [NLANE-1:0]  lane_act;
  logic [NPHASE-1:0] phase_ok;
  logic [PW-1:0]     centre;

  assign busy = run_q | fin_q;
  assign lane_act = (mode_q == 2'd0) ? NLANE'(1) :
                    (mode_q == 2'd1) ? NLANE'(3) : '1;

  for (genvar gs = 0; gs < NS; gs++) begin : g_slot
    assign cap_nx[gs*8 +: 8] = {cap_q[gs*8 +: 6], samp_first[gs], samp_second[gs]};
  end

  for (genvar gp = 0; gp < NPHASE; gp++) begin : g_ph
    logic [NLANE-1:0] hit;
    for (genvar gl = 0; gl < NLANE; gl++) begin : g_ln
      assign hit[gl] = (cap_nx[(gp*NLANE+gl)*8 +: 8] == pattern_q);
    end
    assign phase_ok[gp] = &(hit | ~lane_act);
  end

  always_comb begin
    logic [PW:0]   cur_len, best_len;
    logic [PW-1:0] cur_st, best_st;
    cur_len = '0; best_len = '0; cur_st = '0; best_st = '0;
    for (int i = 0; i < NPHASE; i++) begin
      if (pass_mask[i]) begin
        if (cur_len == '0) cur_st = PW'(i);
        cur_len = cur_len + 1'b1;
        if (cur_len > best_len) begin
          best_len = cur_len;
          best_st  = cur_st;
        end
      end else begin
        cur_len = '0;
      end
    end
    centre = best_st + PW'((best_len - 1'b1) >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      fin_q     <= 1'b0;
      done      <= 1'b0;
      no_eye    <= 1'b0;
      beat_q    <= '0;
      rep_q     <= '0;
      reps_q    <= REP_W'(1);
      mode_q    <= '0;
      cap_q     <= '0;
      pass_mask <= '0;
      phase_sel <= RST_PHASE;
      pattern_q <= PAT_RST;
    end else begin
      done <= 1'b0;
      if (pat_we && !busy) pattern_q <= pat_wdata;
      if (start && !busy) begin
        run_q     <= 1'b1;
        beat_q    <= '0;
        rep_q     <= '0;
        pass_mask <= '1;
        no_eye    <= 1'b0;
        mode_q    <= lane_mode;
        reps_q    <= (reps == '0) ? REP_W'(1) : reps;
      end
      if (run_q && samp_valid) begin
        cap_q  <= cap_nx;
        beat_q <= beat_q + 1'b1;
        if (beat_q == 2'd3) begin
          pass_mask <= pass_mask & phase_ok;
          rep_q     <= rep_q + 1'b1;
          if (REP_W'(rep_q + 1'b1) == reps_q) begin
            run_q <= 1'b0;
            fin_q <= 1'b1;
          end
        end
      end
      if (fin_q) begin
        fin_q <= 1'b0;
        done  <= 1'b1;
        if (|pass_mask) phase_sel <= centre;
        else            no_eye    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_eye_trainer_chk.sv
module ddr_eye_trainer_chk #(
  parameter int NPHASE = 8,
  parameter int PW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              no_eye,
  input logic [NPHASE-1:0] pass_mask,
  input logic [PW-1:0]     phase_sel,
  input logic [7:0]        pattern_q
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R7
  no_eye_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && pass_mask == '0) |-> no_eye);
  // R6
  sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !no_eye) |-> pass_mask[phase_sel]);
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(phase_sel) |-> done);
  // R2
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(pattern_q));
endmodule

bind ddr_eye_trainer ddr_eye_trainer_chk #(.NPHASE(NPHASE), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .no_eye(no_eye), .pass_mask(pass_mask), .phase_sel(phase_sel), .pattern_q(pattern_q)
);

// File: tb/ddr_eye_trainer_test.sv
module ddr_eye_trainer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPHASE = 8;
  localparam int NLANE = 4;
  localparam int NS = NPHASE * NLANE;

  logic clk = 0, rst_n = 0;
  logic pat_we = 0, start = 0, samp_valid = 0;
  logic [7:0] pat_wdata = 0;
  logic [1:0] lane_mode = 2;
  logic [3:0] reps = 1;
  logic [NS-1:0] sf = 0, ss = 0;
  logic busy, done, no_eye;
  logic [NPHASE-1:0] pass_mask;
  logic [2:0] phase_sel;
  logic [7:0] pattern_q;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_eye_trainer uut (
    .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_wdata(pat_wdata),
    .lane_mode(lane_mode), .reps(reps), .start(start), .samp_valid(samp_valid),
    .samp_first(sf), .samp_second(ss), .busy(busy), .done(done), .no_eye(no_eye),
    .pass_mask(pass_mask), .phase_sel(phase_sel), .pattern_q(pattern_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic kick();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic do_read(input logic [7:0] pat, input logic [7:0] good,
                         input logic [3:0] badl, input logic [3:0] junk);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NPHASE; p++) begin
        for (int l = 0; l < NLANE; l++) begin
          logic [7:0] b;
          b = ((!good[p] && badl[l]) || junk[l]) ? (pat ^ 8'h10) : pat;
          sf[p*NLANE+l] = b[7-2*k];
          ss[p*NLANE+l] = b[6-2*k];
        end
      end
      samp_valid = 1;
      @(negedge clk);
    end
    samp_valid = 0;
  endtask

  task automatic finish_chk(input string tag, input int emask, input int esel, input int enoeye);
    check({tag, " R8 no early done"}, {busy, done}, 2'b10);
    @(negedge clk);
    check({tag, " R8 done pulse, busy low"}, {busy, done}, 2'b01);
    check({tag, " R5 pass_mask"}, pass_mask, emask);
    check({tag, " R6 phase_sel"}, phase_sel, esel);
    check({tag, " R7 no_eye"}, no_eye, enoeye);
    @(negedge clk);
    check({tag, " R8 done falls"}, done, 0);
  endtask

  task automatic t_reset();
    check("R1 pattern", pattern_q, 8'h34);
    check("R1 phase_sel", phase_sel, 4);
    check("R1 flags", {busy, done, no_eye}, 0);
    check("R1 pass_mask", pass_mask, 0);
  endtask

  task automatic t_runs();
    lane_mode = 2; reps = 1;
    kick();
    check("R8 busy after start", busy, 1);
    do_read(8'h34, 8'hFF, 4'hF, 4'h0);
    finish_chk("all pass R3", 8'hFF, 3, 0);
    kick(); do_read(8'h34, 8'h7C, 4'h8, 4'h0);
    finish_chk("eye 2-6 R3", 8'h7C, 4, 0);
    kick(); do_read(8'h34, 8'hF1, 4'h1, 4'h0);
    finish_chk("two runs R6", 8'hF1, 5, 0);
    kick(); do_read(8'h34, 8'h33, 4'h4, 4'h0);
    finish_chk("tie R6", 8'h33, 0, 0);
  endtask

  task automatic t_lanes();
    lane_mode = 0; reps = 1;
    kick(); do_read(8'h34, 8'h0F, 4'h1, 4'hE);
    finish_chk("x1 R4", 8'h0F, 1, 0);
    lane_mode = 1;
    kick(); do_read(8'h34, 8'hF0, 4'h2, 4'hC);
    finish_chk("x2 R4", 8'hF0, 5, 0);
    lane_mode = 2;
  endtask

  task automatic t_reps();
    reps = 3;
    kick();
    do_read(8'h34, 8'hFF, 4'hF, 4'h0);
    check("R5 busy between reads", {busy, done}, 2'b10);
    do_read(8'h34, 8'h3C, 4'hF, 4'h0);
    do_read(8'h34, 8'hFC, 4'hF, 4'h0);
    finish_chk("reps3 R5", 8'h3C, 3, 0);
    reps = 0;
    kick(); do_read(8'h34, 8'h0E, 4'h2, 4'h0);
    finish_chk("reps0 R5", 8'h0E, 2, 0);
    reps = 1;
  endtask

  task automatic t_noeye();
    kick(); do_read(8'h34, 8'h00, 4'hF, 4'h0);
    finish_chk("none R7", 8'h00, 2, 1);
    kick();
    check("R7 no_eye cleared on start", no_eye, 0);
    do_read(8'h34, 8'hC0, 4'hF, 4'h0);
    finish_chk("recover R7", 8'hC0, 6, 0);
  endtask

  task automatic t_pattern();
    pat_we = 1; pat_wdata = 8'hA5;
    @(negedge clk);
    pat_we = 0;
    check("R2 idle write", pattern_q, 8'hA5);
    kick();
    pat_we = 1; pat_wdata = 8'h00;
    @(negedge clk);
    pat_we = 0;
    check("R2 busy write ignored", pattern_q, 8'hA5);
    do_read(8'hA5, 8'h1F, 4'hF, 4'h0);
    finish_chk("pattern A5 R3", 8'h1F, 2, 0);
    do_read(8'hA5, 8'h00, 4'hF, 4'h0);
    @(negedge clk);
    check("R8 idle beats ignored", {busy, done, phase_sel}, 2);
    pat_we = 1; pat_wdata = 8'h34;
    @(negedge clk);
    pat_we = 0;
  endtask

  task automatic t_restart();
    reps = 2;
    kick();
    do_read(8'h34, 8'hF8, 4'hF, 4'h0);
    kick();
    do_read(8'h34, 8'h7F, 4'hF, 4'h0);
    finish_chk("start while busy R8", 8'h78, 4, 0);
    reps = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_runs();
    t_lanes();
    t_reps();
    t_noeye();
    t_pattern();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule